// File: doc/BRIEF.md
# LCD Power-On Initialization Sequencer

This block sits on the host side of a character LCD controller-driver. It takes the display from power-up to a running state with no help from software. A single start pulse does three things in turn. First it holds the display's active-low reset pin low for a programmed time. It then leaves the display alone for a programmed recovery wait. Last, it writes six instructions over an 8-bit parallel bus with register-select, read/write and an enable strobe. The display's busy flag is never read. Instead, each instruction gets a fixed slot that is at least one instruction cycle time long, so the next write can never arrive early.

The six instructions are sent in a fixed order:
1. Function set for the normal instruction table.
2. The same function set for the extended table.
3. Bias select.
4. Display on/off.
5. Entry mode.
6. Power-save release, which cancels the low-power state the display enters after reset.

Every field value comes from a parameter. All time counts are worked out from the system clock frequency in kHz and from times given in microseconds. Each count has a floor of one cycle. While the sequence runs, `busy` is high. Once the last slot has expired, `busy` falls and `done` rises. The block stays in that state until a new start.

Top module: `lcd_init_seq`

## Requirements
- R1: After reset the block is idle: `lcd_rst_n`=0, `busy`=0, `done`=0, `lcd_en`=0, `lcd_db`=0.
- R2: A start pulse in the idle state raises `busy` in the next cycle. It holds `lcd_rst_n` low for RL = max(1, RST_LOW_US·CLK_KHZ/1000) cycles, then drives it high for a wait of W = max(1, RST_WAIT_US·CLK_KHZ/1000) cycles with no enable strobe.
- R3: The six instructions appear on `lcd_db` in this order: function set with table bit 0, function set with table bit 1, bias, display, entry, power save. The function-set byte is {3'b001, DL, N, DT, MS, 1'b0}.
- R4: The other encodings are as follows. Bias is {5'b00010, MLC, MLS, BS5}. Display is {5'b00001, D, C, B}. Entry is {6'b000001, ID, S}. Power save is {7'b0000001, PS}, always sent with PS=0. Each field comes from its parameter.
- R5: Within a slot, `lcd_db` is held constant for the whole slot, and `lcd_rs`=`lcd_rw`=0 throughout. `lcd_en` is low for SETUP_CYC cycles, then high for EN_CYC cycles, then low for the rest of the slot.
- R6: Each slot lasts S = max(T, SETUP_CYC+EN_CYC+HOLD_CYC) cycles, where T = max(1, TCYC_US·CLK_KHZ/1000). Consecutive rising edges of `lcd_en` are therefore exactly S cycles apart, and never fewer than T.
- R7: In the cycle after the last slot ends, `busy`=0, `done`=1, `lcd_rst_n`=1, `lcd_en`=0 and `lcd_db`=0. This state holds while `start` stays low.
- R8: A start pulse while `busy` is high is ignored. This includes a pulse in the final cycle of the last slot; the timeline continues unchanged.
- R9: A start pulse while `done` is high clears `done` and replays the full sequence from R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begins the power-on sequence when idle or done |
| lcd_rst_n | output | 1 | Active-low reset to the display |
| lcd_rs | output | 1 | Register select, always instruction (0) |
| lcd_rw | output | 1 | Read/write select, always write (0) |
| lcd_en | output | 1 | Enable strobe |
| lcd_db | output | 8 | Instruction byte |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished |

## Verification
Two events can land in the same clock edge: the expiry of the final slot, which moves the block to done, and the arrival of a new start request. The bench raises `start` during the last cycle of the sixth slot. It then checks that `done` rises on schedule and stays high, with no reset pulse and no strobe after it. It also checks that `start` in the done state does replay the sequence. Both checks run against two parameter sets: in one the cycle time sets the slot length, and in the other the strobe frame does.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;

  localparam int unsigned NUM_INSTR = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_WAIT,
    ST_SLOT,
    ST_DONE
  } seq_state_e;

  // convert microseconds to clock cycles, never below one cycle
  function automatic int unsigned us_to_cyc(int unsigned us, int unsigned khz);
    longint unsigned c;
    c = (longint'(us) * longint'(khz)) / 1000;
    return (c < 1) ? 1 : int'(c);
  endfunction

  function automatic logic [7:0] enc_fset(logic dl, logic n, logic dt, logic ms);
    return {3'b001, dl, n, dt, ms, 1'b0};
  endfunction

  function automatic logic [7:0] enc_bias(logic mlc, logic mls, logic bs5);
    return {5'b00010, mlc, mls, bs5};
  endfunction

  function automatic logic [7:0] enc_disp(logic d, logic c, logic b);
    return {5'b00001, d, c, b};
  endfunction

  function automatic logic [7:0] enc_entry(logic id, logic s);
    return {6'b000001, id, s};
  endfunction

  function automatic logic [7:0] enc_psave(logic ps);
    return {7'b0000001, ps};
  endfunction

endpackage

// File: rtl/lcd_init_timer.sv
module lcd_init_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    if (load) begin
      cnt_nxt = load_val;
    end else if (cnt != '0) begin
      cnt_nxt = cnt - 1'b1;
    end else begin
      cnt_nxt = cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      cnt <= cnt_nxt;
    end
  end

  assign zero = (cnt == '0);

  // R6: the counter never wraps below zero between loads
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero);

endmodule

// File: rtl/lcd_init_rom.sv
module lcd_init_rom
  import lcd_init_pkg::*;
#(
  parameter int unsigned IDX_W    = 3,
  parameter bit          FS_DL    = 1'b1,
  parameter bit          FS_N     = 1'b0,
  parameter bit          FS_DT    = 1'b0,
  parameter bit          BIAS_MLC = 1'b0,
  parameter bit          BIAS_MLS = 1'b0,
  parameter bit          BIAS_BS5 = 1'b1,
  parameter bit          DISP_D   = 1'b1,
  parameter bit          DISP_C   = 1'b1,
  parameter bit          DISP_B   = 1'b0,
  parameter bit          ENT_ID   = 1'b0,
  parameter bit          ENT_S    = 1'b0
) (
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       code
);

  // order of entries is the required issue order (R3)
  always_comb begin
    case (idx)
      IDX_W'(0): code = enc_fset(FS_DL, FS_N, FS_DT, 1'b0);
      IDX_W'(1): code = enc_fset(FS_DL, FS_N, FS_DT, 1'b1);
      IDX_W'(2): code = enc_bias(BIAS_MLC, BIAS_MLS, BIAS_BS5);
      IDX_W'(3): code = enc_disp(DISP_D, DISP_C, DISP_B);
      IDX_W'(4): code = enc_entry(ENT_ID, ENT_S);
      IDX_W'(5): code = enc_psave(1'b0);
      default:   code = 8'h00;
    endcase
  end

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_init_pkg::*;
#(
  parameter int unsigned CLK_KHZ     = 125000,
  parameter int unsigned RST_LOW_US  = 10,
  parameter int unsigned RST_WAIT_US = 2000,
  parameter int unsigned TCYC_US     = 500,
  parameter int unsigned SETUP_CYC   = 4,
  parameter int unsigned EN_CYC      = 60,
  parameter int unsigned HOLD_CYC    = 4,
  parameter bit          FS_DL       = 1'b1,
  parameter bit          FS_N        = 1'b0,
  parameter bit          FS_DT       = 1'b0,
  parameter bit          BIAS_MLC    = 1'b0,
  parameter bit          BIAS_MLS    = 1'b0,
  parameter bit          BIAS_BS5    = 1'b1,
  parameter bit          DISP_D      = 1'b1,
  parameter bit          DISP_C      = 1'b1,
  parameter bit          DISP_B      = 1'b0,
  parameter bit          ENT_ID      = 1'b0,
  parameter bit          ENT_S       = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       lcd_rst_n,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_en,
  output logic [7:0] lcd_db,
  output logic       busy,
  output logic       done
);

  localparam int unsigned RST_LOW_CYC = us_to_cyc(RST_LOW_US, CLK_KHZ);
  localparam int unsigned WAIT_CYC    = us_to_cyc(RST_WAIT_US, CLK_KHZ);
  localparam int unsigned TCYC_CYC    = us_to_cyc(TCYC_US, CLK_KHZ);
  localparam int unsigned FRAME_CYC   = SETUP_CYC + EN_CYC + HOLD_CYC;
  localparam int unsigned SLOT_CYC    = (TCYC_CYC > FRAME_CYC) ? TCYC_CYC : FRAME_CYC;
  localparam int unsigned MAX_A       = (RST_LOW_CYC > WAIT_CYC) ? RST_LOW_CYC : WAIT_CYC;
  localparam int unsigned MAX_CNT     = (MAX_A > SLOT_CYC) ? MAX_A : SLOT_CYC;
  localparam int unsigned CNT_W       = $clog2(MAX_CNT + 1);
  localparam int unsigned IDX_W       = $clog2(NUM_INSTR);
  localparam int unsigned GAP_W       = CNT_W + 1;

  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_INSTR - 1);
  localparam logic [CNT_W-1:0] RST_LOAD  = CNT_W'(RST_LOW_CYC - 1);
  localparam logic [CNT_W-1:0] WAIT_LOAD = CNT_W'(WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] SLOT_LOAD = CNT_W'(SLOT_CYC - 1);
  localparam logic [CNT_W-1:0] EN_LO     = CNT_W'(SETUP_CYC);
  localparam logic [CNT_W-1:0] EN_HI     = CNT_W'(SETUP_CYC + EN_CYC);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign srst_n = rsync_q[1];

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic [CNT_W-1:0] tmr_cnt;
  logic             tmr_zero;
  logic [7:0]       rom_code;
  logic [CNT_W-1:0] slot_pos;

  lcd_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .cnt      (tmr_cnt),
    .zero     (tmr_zero)
  );

  lcd_init_rom #(
    .IDX_W    (IDX_W),
    .FS_DL    (FS_DL),
    .FS_N     (FS_N),
    .FS_DT    (FS_DT),
    .BIAS_MLC (BIAS_MLC),
    .BIAS_MLS (BIAS_MLS),
    .BIAS_BS5 (BIAS_BS5),
    .DISP_D   (DISP_D),
    .DISP_C   (DISP_C),
    .DISP_B   (DISP_B),
    .ENT_ID   (ENT_ID),
    .ENT_S    (ENT_S)
  ) u_rom (
    .idx  (idx_q),
    .code (rom_code)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          state_d  = ST_RST;
          tmr_load = 1'b1;
          tmr_val  = RST_LOAD;
        end
      end
      ST_RST: begin
        if (tmr_zero) begin
          state_d  = ST_WAIT;
          tmr_load = 1'b1;
          tmr_val  = WAIT_LOAD;
        end
      end
      ST_WAIT: begin
        if (tmr_zero) begin
          state_d  = ST_SLOT;
          idx_d    = '0;
          tmr_load = 1'b1;
          tmr_val  = SLOT_LOAD;
        end
      end
      ST_SLOT: begin
        if (tmr_zero) begin
          if (idx_q == LAST_IDX) begin
            state_d = ST_DONE;
          end else begin
            idx_d    = idx_q + 1'b1;
            tmr_load = 1'b1;
            tmr_val  = SLOT_LOAD;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  // strobe decode from the position inside the slot
  assign slot_pos  = SLOT_LOAD - tmr_cnt;
  assign lcd_en    = (state_q == ST_SLOT) && (slot_pos >= EN_LO) && (slot_pos < EN_HI);
  assign lcd_db    = (state_q == ST_SLOT) ? rom_code : 8'h00;
  assign lcd_rs    = 1'b0;
  assign lcd_rw    = 1'b0;
  assign lcd_rst_n = !((state_q == ST_IDLE) || (state_q == ST_RST));
  assign busy      = (state_q == ST_RST) || (state_q == ST_WAIT) || (state_q == ST_SLOT);
  assign done      = (state_q == ST_DONE);

  // checker state: strobe spacing
  logic             en_q;
  logic             seen_en_q;
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      en_q      <= 1'b0;
      seen_en_q <= 1'b0;
      gap_q     <= '0;
    end else begin
      en_q <= lcd_en;
      if (lcd_en && !en_q) begin
        seen_en_q <= 1'b1;
        gap_q     <= GAP_W'(1);
      end else if (gap_q != '1) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  a_r6_min_spacing: assert property (@(posedge clk) disable iff (!srst_n)
    (lcd_en && !en_q && seen_en_q) |-> (gap_q >= GAP_W'(TCYC_CYC)));

  a_r5_db_stable: assert property (@(posedge clk) disable iff (!srst_n)
    (lcd_en && en_q) |-> $stable(lcd_db));

  a_r2_no_strobe_in_reset: assert property (@(posedge clk) disable iff (!srst_n)
    !lcd_rst_n |-> !lcd_en);

  a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (!srst_n)
    !(busy && done));

  a_r7_done_holds: assert property (@(posedge clk) disable iff (!srst_n)
    (done && !start) |=> done);

  a_r8_busy_ignores_start: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && lcd_rst_n) |=> lcd_rst_n);

endmodule

// File: tb/lcd_init_seq_test.sv
`timescale 1ns/1ps
module lcd_init_seq_test;

  logic clk;
  logic rst_n;
  logic start_drv;
  logic sel;
  int   n_checks;
  int   n_fail;
  bit   finished;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  logic a_rstn, a_rs, a_rw, a_en, a_busy, a_done;
  logic b_rstn, b_rs, b_rw, b_en, b_busy, b_done;
  logic [7:0] a_db, b_db;
  logic start_a, start_b;

  assign start_a = start_drv & !sel;
  assign start_b = start_drv & sel;

  // config A: cycle time sets slot (RL=3, W=20, T=5, frame 1+2+1 -> S=5)
  lcd_init_seq #(
    .CLK_KHZ(10), .RST_LOW_US(300), .RST_WAIT_US(2000), .TCYC_US(500),
    .SETUP_CYC(1), .EN_CYC(2), .HOLD_CYC(1)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start_a),
    .lcd_rst_n(a_rstn), .lcd_rs(a_rs), .lcd_rw(a_rw), .lcd_en(a_en),
    .lcd_db(a_db), .busy(a_busy), .done(a_done)
  );

  // config B: strobe frame sets slot (RL=1, W=5, T=3, frame 2+3+2 -> S=7), other fields
  lcd_init_seq #(
    .CLK_KHZ(10), .RST_LOW_US(100), .RST_WAIT_US(500), .TCYC_US(300),
    .SETUP_CYC(2), .EN_CYC(3), .HOLD_CYC(2),
    .FS_DL(1'b0), .FS_N(1'b1), .FS_DT(1'b1),
    .BIAS_MLC(1'b1), .BIAS_MLS(1'b0), .BIAS_BS5(1'b0),
    .DISP_D(1'b1), .DISP_C(1'b0), .DISP_B(1'b1),
    .ENT_ID(1'b1), .ENT_S(1'b1)
  ) uut_b (
    .clk(clk), .rst_n(rst_n), .start(start_b),
    .lcd_rst_n(b_rstn), .lcd_rs(b_rs), .lcd_rw(b_rw), .lcd_en(b_en),
    .lcd_db(b_db), .busy(b_busy), .done(b_done)
  );

  logic m_rstn, m_rs, m_rw, m_en, m_busy, m_done;
  logic [7:0] m_db;
  always_comb begin
    if (sel) begin
      {m_rstn, m_rs, m_rw, m_en, m_busy, m_done, m_db} = {b_rstn, b_rs, b_rw, b_en, b_busy, b_done, b_db};
    end else begin
      {m_rstn, m_rs, m_rw, m_en, m_busy, m_done, m_db} = {a_rstn, a_rs, a_rw, a_en, a_busy, a_done, a_db};
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // expected instruction byte, computed from the R3/R4 field layouts
  function automatic int exp_code(input int inst, input int i);
    int dl, n, dt, mlc, mls, bs, d, c, b, id, s;
    if (inst == 0) begin
      dl = 1; n = 0; dt = 0; mlc = 0; mls = 0; bs = 1; d = 1; c = 1; b = 0; id = 0; s = 0;
    end else begin
      dl = 0; n = 1; dt = 1; mlc = 1; mls = 0; bs = 0; d = 1; c = 0; b = 1; id = 1; s = 1;
    end
    case (i)
      0: return 32 + dl*16 + n*8 + dt*4;
      1: return 32 + dl*16 + n*8 + dt*4 + 2;
      2: return 16 + mlc*4 + mls*2 + bs;
      3: return 8 + d*4 + c*2 + b;
      4: return 4 + id*2 + s;
      default: return 2;
    endcase
  endfunction

  // pulse_t: -1 none, -2 final cycle of last slot, else cycle offset
  task automatic run_seq(input int inst, input int pulse_t);
    int rl, wt, sl, su, en, total, pt;
    if (inst == 0) begin
      rl = 3; wt = 20; sl = 5; su = 1; en = 2;
    end else begin
      rl = 1; wt = 5; sl = 7; su = 2; en = 3;
    end
    total = rl + wt + 6*sl;
    pt = (pulse_t == -2) ? total - 1 : pulse_t;
    sel = inst[0];
    @(negedge clk);
    start_drv = 1'b1;
    @(negedge clk);
    start_drv = 1'b0;
    for (int t = 0; t < total + 4; t++) begin
      int e_rstn, e_busy, e_done, e_en, e_db;
      if (t < rl) begin
        e_rstn = 0; e_busy = 1; e_done = 0; e_en = 0; e_db = 0;
      end else if (t < rl + wt) begin
        e_rstn = 1; e_busy = 1; e_done = 0; e_en = 0; e_db = 0;
      end else if (t < total) begin
        int i, p;
        i = (t - rl - wt) / sl;
        p = (t - rl - wt) % sl;
        e_rstn = 1; e_busy = 1; e_done = 0;
        e_en = (p >= su && p < su + en) ? 1 : 0;
        e_db = exp_code(inst, i);
      end else begin
        e_rstn = 1; e_busy = 0; e_done = 1; e_en = 0; e_db = 0;
      end
      chk((t < rl + wt) ? "R2 lcd_rst_n" : "R9 lcd_rst_n", int'(m_rstn), e_rstn);
      chk((t < total) ? "R8 busy" : "R7 busy", int'(m_busy), e_busy);
      chk((t < total) ? "R9 done" : "R7 done", int'(m_done), e_done);
      chk((t < total) ? "R6 lcd_en" : "R7 lcd_en", int'(m_en), e_en);
      chk((t < total) ? "R3 R4 lcd_db" : "R7 lcd_db", int'(m_db), e_db);
      chk("R5 rs_rw", int'({m_rs, m_rw}), 0);
      start_drv = (t == pt) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    start_drv = 1'b0;
  endtask

  initial begin
    finished = 1'b0;
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    n_checks = 0;
    n_fail = 0;
    sel = 1'b0;
    start_drv = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 idle state on both configurations
    for (int k = 0; k < 2; k++) begin
      sel = k[0];
      #1;
      chk("R1 lcd_rst_n", int'(m_rstn), 0);
      chk("R1 busy", int'(m_busy), 0);
      chk("R1 done", int'(m_done), 0);
      chk("R1 lcd_en", int'(m_en), 0);
      chk("R1 lcd_db", int'(m_db), 0);
    end
    for (int k = 0; k < 2; k++) begin
      run_seq(k, -1);   // R2..R7 plain run
      run_seq(k, 4);    // R9 restart from done, R8 pulse while busy
      run_seq(k, -2);   // R8 pulse in the last slot cycle
      repeat (3) begin  // R7 done stays after the ignored pulse
        chk("R7 done hold", int'(m_done), 1);
        chk("R7 no reset", int'(m_rstn), 1);
        @(negedge clk);
      end
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule